// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A synthesizable behavioural model of a single-port synchronous static memory whose bus never needs an idle cycle between a read and a write. The address and control lines are sampled on a rising clock edge. The data transfer for that command takes place in the clock cycle that follows. A read command therefore drives the bus during its data cycle, and a write command takes its data from the bus during its data cycle. Because each data cycle trails its command by one cycle, reads and writes can alternate on every clock.

Each word is 36 bits wide and is split into four 9-bit lanes. The depth is set by a parameter. Read data leaves the array without an output register, so it appears in the same data cycle. The tri-state bus is modelled as three ports: an input, an output and an output enable.

Other controls:

- A clock-hold input freezes the model.
- Three select inputs must all be active for a new command to start.
- An advance input continues a four-word burst. The order is either linear or interleaved.
- An asynchronous output-enable input can silence the bus at any time.

The controller is a three-state machine, and its state is the operation of the current data cycle:

- **IDLE**: no transfer.
- **READ**: the array word drives the bus.
- **WRITE**: bus data is written at the end of the cycle.

The transitions, taken on a clock edge while clock-hold is low, are:

- **LOAD_RD**: `advance` low, all selects active, `rd_nwr` high; next state READ.
- **LOAD_WR**: the same with `rd_nwr` low; next state WRITE.
- **DESEL**: `advance` low with any select inactive; next state IDLE.
- **ADV**: `advance` high; the state stays the same, and the burst count steps when the state is not IDLE.
- **HOLD**: `clk_hold` high; every register is frozen.

Top module: `zbt_sram`

## Requirements
- R1: While reset is applied, and after it is released with no command issued, `dq_oe` is 0.
- R2: A read command captured at edge k drives `dq_oe`=1 and `dq_out` = the addressed word during the cycle between edges k and k+1. The data comes straight from the array, and `out_en_n` must be low.
- R3: Bit i of `lane_wr_n` is active low. When it is 0, lane i (bits 9i+8..9i) of the addressed word takes `dq_in` as sampled at the edge that ends the write's data cycle. When it is 1, lane i keeps its old value. The lane selects are captured with the command.
- R4: While `clk_hold` is 1, every input except `out_en_n` is ignored. No write is committed, the burst does not advance, and the bus output stays as it was.
- R5: When `advance` is 0 and any of `sel_a_n`=1, `sel_b`=0 or `sel_c_n`=1 holds, the cycle is a deselect. `dq_oe` is 0 in the following cycle.
- R6: A read or write issued just before a deselect still completes its data cycle.
- R7: In the data cycle of a write, `dq_oe` is 0.
- R8: `out_en_n`=1 forces `dq_oe` to 0 at once, in any state.
- R9: Reads and writes may alternate on consecutive edges with no dead cycle. A read of the address written by the immediately preceding command returns the new data.
- R10: When `advance` is 1 after a read or write, the same operation repeats at the next burst address. Beat n (n=0..3) uses the loaded address with its two low bits replaced as follows. With `lin_order`=1 they become (low+n) mod 4. With `lin_order`=0 they become low XOR n.
- R11: When `advance` is 1 after a deselect, the model stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control registers |
| clk_hold | input | 1 | 1 freezes all synchronous activity |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| rd_nwr | input | 1 | 1 read, 0 write |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| advance | input | 1 | 1 continues the burst, 0 loads a new command |
| lin_order | input | 1 | 1 linear burst order, 0 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 36 | Bus data into the model |
| dq_out | output | 36 | Bus data out of the model |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The assertions check several behaviours on every cycle:

- a hold freezes the state, the base address and the burst count;
- a deselect yields IDLE;
- an advance keeps the operation type, including IDLE;
- a write command releases the bus in its data cycle;
- a read command drives the bus unless output enable is off.

Other behaviours can only be shown by the bench's scenarios, which compare bus data against a reference array:

- the stored contents after lane-masked writes;
- the order of burst addresses;
- read-after-write forwarding through the array;
- completion of a write that is pending when a deselect arrives.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    // Operation of the current data cycle
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } zbt_state_e;

    localparam int BURST_W = 2;
endpackage

// File: rtl/zbt_burst_addr.sv
module zbt_burst_addr
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [BURST_W-1:0] cnt,
    input  logic               lin_order,
    output logic [ADDR_W-1:0]  word_addr
);
    logic [BURST_W-1:0] low;

    always_comb begin
        if (lin_order) low = base[BURST_W-1:0] + cnt;
        else           low = base[BURST_W-1:0] ^ cnt;
    end

    generate
        if (ADDR_W > BURST_W) begin : g_wide
            assign word_addr = {base[ADDR_W-1:BURST_W], low};
        end else begin : g_narrow
            assign word_addr = low;
        end
    endgenerate
endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               advance,
    input  logic               sel_ok,
    input  logic               rd_nwr,
    input  logic [LANES-1:0]   lane_wr_n,
    input  logic [ADDR_W-1:0]  addr,
    output zbt_state_e         state,
    output logic [ADDR_W-1:0]  base,
    output logic [BURST_W-1:0] cnt,
    output logic [LANES-1:0]   lane_q_n
);
    zbt_state_e         nxt;
    logic [ADDR_W-1:0]  base_nxt;
    logic [BURST_W-1:0] cnt_nxt;

    // Next-state and burst bookkeeping
    always_comb begin
        nxt      = state;
        base_nxt = base;
        cnt_nxt  = cnt;
        if (!advance) begin
            base_nxt = addr;
            cnt_nxt  = '0;
        end
        unique case (state)
            ST_IDLE, ST_READ, ST_WRITE: begin
                if (!advance) begin
                    if (!sel_ok)     nxt = ST_IDLE;   // DESEL
                    else if (rd_nwr) nxt = ST_READ;   // LOAD_RD
                    else             nxt = ST_WRITE;  // LOAD_WR
                end else begin
                    nxt = state;                      // ADV
                    if (state != ST_IDLE) cnt_nxt = cnt + 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register (HOLD freezes everything)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            base     <= '0;
            cnt      <= '0;
            lane_q_n <= '1;
        end else if (!hold) begin
            state    <= nxt;
            base     <= base_nxt;
            cnt      <= cnt_nxt;
            lane_q_n <= lane_wr_n;
        end
    end

    // R4
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(state) && $stable(base) && $stable(cnt)));
    // R5
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !advance && !sel_ok) |=> (state == ST_IDLE));
    // R11
    adv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && advance && state == ST_IDLE) |=> (state == ST_IDLE));
    // R10
    adv_same_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && advance) |=> (state == $past(state)));
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       word_addr,
    input  logic [LANES-1:0]        lane_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];
            always_ff @(posedge clk) begin
                if (we && !lane_n[g]) mem[word_addr] <= din[g*LANE_W +: LANE_W];
            end
            assign dout[g*LANE_W +: LANE_W] = mem[word_addr];
        end
    endgenerate
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_hold,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    rd_nwr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    advance,
    input  logic                    lin_order,
    input  logic                    out_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    zbt_state_e         state;
    logic [ADDR_W-1:0]  base;
    logic [ADDR_W-1:0]  word_addr;
    logic [BURST_W-1:0] cnt;
    logic [LANES-1:0]   lane_q_n;
    logic               sel_ok;
    logic               commit;

    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hold(clk_hold), .advance(advance),
        .sel_ok(sel_ok), .rd_nwr(rd_nwr), .lane_wr_n(lane_wr_n), .addr(addr),
        .state(state), .base(base), .cnt(cnt), .lane_q_n(lane_q_n)
    );

    zbt_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .base(base), .cnt(cnt), .lin_order(lin_order), .word_addr(word_addr)
    );

    assign commit = (state == ST_WRITE) && !clk_hold;

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .we(commit), .word_addr(word_addr), .lane_n(lane_q_n),
        .din(dq_in), .dout(dq_out)
    );

    // Output process: flow-through drive, asynchronous enable
    always_comb begin
        dq_oe = 1'b0;
        unique case (state)
            ST_READ:  dq_oe = !out_en_n;
            ST_WRITE: dq_oe = 1'b0;
            ST_IDLE:  dq_oe = 1'b0;
            default:  dq_oe = 1'b0;
        endcase
    end

    // R7
    wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && !advance && sel_ok && !rd_nwr) |=> !dq_oe);
    // R2
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && !advance && sel_ok && rd_nwr) |=> (out_en_n || dq_oe));
endmodule

// File: tb/sim_zbt_sram.sv
module sim_zbt_sram;
    localparam int AW = 4;
    localparam int DW = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_hold = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic rd_nwr = 1'b1, advance = 1'b0, lin_order = 1'b1, out_en_n = 1'b0;
    logic [3:0] lane_wr_n = 4'hf;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    zbt_sram u0 (
        .clk(clk), .rst_n(rst_n), .clk_hold(clk_hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .rd_nwr(rd_nwr), .lane_wr_n(lane_wr_n), .advance(advance),
        .lin_order(lin_order), .out_en_n(out_en_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Reference state, computed from the requirements
    logic [DW-1:0] mm [16];
    int m_op = 0;               // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_cnt = '0;
    logic [3:0] m_bw = 4'hf;
    logic [DW-1:0] held_wd = '0;

    function automatic logic [AW-1:0] maddr();
        logic [1:0] lo;
        lo = lin_order ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt;
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] pat(input int n);
        logic [31:0] h;
        h = n * 32'h9E3779B9 + 32'h1234;
        return {n[3:0] ^ 4'h5, h};
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit hold, input bit adv, input bit an,
                        input bit b, input bit cn, input bit rw, input logic [3:0] bw,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd, input bit oen);
        bit exp_oe;
        @(negedge clk);
        exp_oe = (m_op == 1) && !out_en_n;
        chk(tag, {35'd0, dq_oe}, {35'd0, exp_oe});
        if (exp_oe) chk(tag, dq_out, mm[maddr()]);
        clk_hold = hold; advance = adv; sel_a_n = an; sel_b = b; sel_c_n = cn;
        rd_nwr = rw; lane_wr_n = bw; addr = a; out_en_n = oen; dq_in = held_wd;
        #1;
        if (oen) chk("R8", {35'd0, dq_oe}, 36'd0);
        if (!hold) begin
            if (m_op == 2)
                for (int l = 0; l < 4; l++)
                    if (!m_bw[l]) mm[maddr()][l*9 +: 9] = held_wd[l*9 +: 9];
            if (!adv) begin
                if (!an && b && !cn) begin
                    m_op = rw ? 1 : 2; m_base = a; m_cnt = 0;
                end else m_op = 0;
            end else if (m_op != 0) m_cnt = m_cnt + 1'b1;
            m_bw = bw;
            held_wd = wd;
        end
    endtask

    task automatic wr(input string t, input int a, input logic [3:0] bw, input logic [DW-1:0] d);
        step(t, 0, 0, 0, 1, 0, 0, bw, AW'(a), d, 0);
    endtask
    task automatic rd(input string t, input int a);
        step(t, 0, 0, 0, 1, 0, 1, 4'hf, AW'(a), '0, 0);
    endtask
    task automatic adv(input string t, input logic [DW-1:0] d);
        step(t, 0, 1, 0, 1, 0, 1, 4'h0, '0, d, 0);
    endtask
    task automatic nop(input string t);
        step(t, 0, 0, 1, 0, 1, 1, 4'hf, '0, '0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", {35'd0, dq_oe}, 36'd0);
        rst_n = 1'b1;
        nop("R1");
        nop("R1");

        // Fill every word, then read every word back
        for (int a = 0; a < 16; a++) wr("R3", a, 4'h0, pat(a));
        for (int a = 0; a < 16; a++) rd("R2", a);
        nop("R2");

        // Back-to-back alternation on the same and neighbouring words
        for (int a = 0; a < 16; a++) begin
            wr("R9", a, 4'h0, pat(a + 100));
            rd("R9", a);
        end
        for (int a = 0; a < 16; a++) begin
            rd("R9", a);
            wr("R7", (a + 1) % 16, 4'h0, pat(a + 150));
        end
        nop("R7");

        // Every lane-select combination
        for (int b = 0; b < 16; b++) begin
            wr("R3", 5, 4'(b), pat(b + 200));
            rd("R3", 5);
        end
        nop("R3");

        // Bursts, both orders, reads and writes
        for (int lo = 0; lo < 2; lo++) begin
            lin_order = lo[0];
            for (int bs = 0; bs < 8; bs++) begin
                wr("R10", bs, 4'h0, pat(bs * 7 + lo));
                adv("R10", pat(bs * 7 + lo + 1));
                adv("R10", pat(bs * 7 + lo + 2));
                adv("R10", pat(bs * 7 + lo + 3));
                rd("R10", bs);
                adv("R10", '0); adv("R10", '0); adv("R10", '0);
                nop("R10");
            end
        end
        lin_order = 1'b1;

        // Deselect by each select, with a pending write and a pending read
        for (int k = 0; k < 3; k++) begin
            wr("R6", 9, 4'h0, pat(300 + k));
            step("R5", 0, 0, k == 0, k != 1, k == 2, 1, 4'hf, '0, '0, 0);
            adv("R11", '0);
            adv("R11", '0);
            rd("R6", 9);
            step("R5", 0, 0, k == 0, k != 1, k == 2, 0, 4'h0, 4'd3, '0, 0);
            nop("R6");
        end

        // Hold during a read, then during a write
        rd("R4", 2);
        for (int h = 0; h < 3; h++) step("R4", 1, 0, 0, 1, 0, 0, 4'h0, 4'd6, pat(h + 500), 0);
        nop("R4");
        wr("R4", 4, 4'h0, pat(400));
        for (int h = 0; h < 3; h++) step("R4", 1, 1, 0, 1, 0, 1, 4'h0, 4'd4, pat(h + 600), 0);
        nop("R4");
        rd("R4", 4);
        rd("R4", 6);
        nop("R4");

        // Output enable off mid-read
        rd("R8", 7);
        step("R8", 0, 1, 0, 1, 0, 1, 4'hf, '0, '0, 1);
        step("R8", 0, 0, 1, 0, 1, 1, 4'hf, '0, '0, 0);
        nop("R8");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule